// File: doc/BRIEF.md
# Minute Time-Code Frame Decoder

This block sits behind a radio time-code pulse synchroniser. It takes one qualified data bit per second (a one-cycle `bit_vld` strobe with `bit_val`), a one-cycle start-of-minute strobe, and an abort input. It collects the bits of one minute frame and checks the constant marker bits, the three even-parity groups, the zone bits and the BCD digit ranges. When the next start-of-minute strobe arrives, a fully consistent frame is published as BCD time and date fields plus five status flags, and `frame_ok` pulses for one cycle. The decoded time is the time of the minute that begins at that strobe.

A bit value of 1 stands for a long (about 200 ms) pulse and 0 for a short (about 100 ms) pulse. Frame position k is the k-th bit strobe after the start-of-minute strobe, counting from 0. A rejected frame leaves every output at its last published value.

The controller has two states. HUNT waits for a start-of-minute strobe and ignores bits. COLLECT stores bits and counts them. The transitions are MARK_SEEN (HUNT to COLLECT on a strobe), MINUTE_END (COLLECT to COLLECT on a strobe: judge the frame, then restart the count), ABORT (COLLECT to HUNT on `frame_abort`) and OVERRUN (COLLECT to HUNT when a bit arrives with every slot already full). An abort takes priority over a strobe in the same cycle, and a strobe takes priority over a bit in the same cycle.

Top module: `tcd_decoder`

## Requirements
- R1: After reset all field and flag outputs are 0, `frame_ok` is 0 and the block is in HUNT. Bits that arrive before the first start-of-minute strobe are ignored, so that strobe never yields `frame_ok`.
- R2: Fields are read LSB first. Minutes come from positions 21–27, giving `min_bcd[6:0]` (units in [3:0], tens in [6:4]). Hours come from 29–34, giving `hour_bcd[5:0]`. Day of month comes from 36–41, giving `mday_bcd[5:0]`. Day of week comes from 42–44, giving `wday`. Month comes from 45–49, giving `month_bcd[4:0]`. Year comes from 50–57, giving `year_bcd[7:0]`. An accepted frame drives these outputs and `frame_ok` in the cycle after the edge that samples the strobe.
- R3: Position 0 must be 0 and position 20 must be 1. Otherwise the frame is rejected.
- R4: Even parity must hold over 21–28, over 29–35 and over 36–58. Any failure rejects the frame.
- R5: Positions 17 and 18 must differ. If both are 0 or both are 1, the frame is rejected.
- R6: Every BCD units digit must be 9 or less, and the year tens digit must be 9 or less. Minutes above 59, hours above 23, month 0, month above 12 and day of week 0 are rejected.
- R7: A frame of exactly 59 bits is eligible. Fewer bits are rejected at the strobe. A bit that arrives when all slots are full causes OVERRUN to HUNT, and the following strobe yields no `frame_ok`.
- R8: With `LEAP_ENABLE`=1, a 60-bit frame is eligible only when position 19 is 1 and position 59 is 0.
- R9: `frame_abort` discards the partial frame and enters HUNT. The next strobe only restarts collection and yields no `frame_ok`.
- R10: A rejected frame leaves all field and flag outputs unchanged.
- R11: `frame_ok` is high for exactly one cycle per accepted frame.
- R12: The flags are read from fixed positions: `call_flag` from 15, `zone_ann` from 16, `summer_zone` from 17, `winter_zone` from 18 and `leap_ann` from 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | One-cycle strobe: a qualified bit is present |
| bit_val | input | 1 | Bit value (1 = long pulse, 0 = short pulse) |
| minute_mark | input | 1 | One-cycle start-of-minute strobe |
| frame_abort | input | 1 | Discard the current frame and hunt |
| min_bcd | output | 7 | Minutes, BCD |
| hour_bcd | output | 6 | Hours, BCD |
| mday_bcd | output | 6 | Day of month, BCD |
| wday | output | 3 | Day of week, 1 = Monday |
| month_bcd | output | 5 | Month, BCD |
| year_bcd | output | 8 | Year within century, BCD |
| call_flag | output | 1 | Abnormal-operation call bit |
| zone_ann | output | 1 | Zone change announced |
| summer_zone | output | 1 | UTC+2 in effect |
| winter_zone | output | 1 | UTC+1 in effect |
| leap_ann | output | 1 | Leap second announced |
| frame_ok | output | 1 | One-cycle accepted-frame strobe |

## Verification
The bench builds the block with `LEAP_ENABLE`=1. This gives 60 storage slots, so both the 60-bit leap frame and its rejection cases can be reached, and OVERRUN is provoked by a 61st bit. The 59-slot variant is only elaborated and is not exercised. Each rejection case is placed after an accepted frame, so that the held outputs can be compared with known values.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
    localparam int unsigned BASE_BITS  = 59;
    localparam int unsigned POS_START  = 0;
    localparam int unsigned POS_CALL   = 15;
    localparam int unsigned POS_ZANN   = 16;
    localparam int unsigned POS_SUMMER = 17;
    localparam int unsigned POS_WINTER = 18;
    localparam int unsigned POS_LEAP   = 19;
    localparam int unsigned POS_TIME   = 20;
    localparam int unsigned POS_EXTRA  = 59;

    typedef enum logic [0:0] {
        ST_HUNT    = 1'b0,
        ST_COLLECT = 1'b1
    } dec_state_t;

    typedef struct packed {
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] mday;
        logic [2:0] wday;
        logic [4:0] mon;
        logic [7:0] year;
        logic       call;
        logic       zone_ann;
        logic       summer;
        logic       winter;
        logic       leap_ann;
    } stamp_t;
endpackage

// File: rtl/tcd_bit_store.sv
module tcd_bit_store
    import tcd_pkg::*;
#(
    parameter int unsigned MAX_BITS = 60,
    parameter int unsigned CW       = $clog2(MAX_BITS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic                       wr_val,
    output logic                       start_bit,
    output logic [MAX_BITS-1:POS_CALL] kept,
    output logic [CW-1:0]              count,
    output logic                       full
);
    assign full = (count == CW'(MAX_BITS));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (wr_en && !full) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            start_bit <= 1'b0;
        end else if (wr_en && count == '0) begin
            start_bit <= wr_val;
        end
    end

    // Positions 1..14 carry nothing this block uses: count them, keep no flop.
    for (genvar g = POS_CALL; g < MAX_BITS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                kept[g] <= 1'b0;
            end else if (wr_en && !full && count == CW'(g)) begin
                kept[g] <= wr_val;
            end
        end
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(MAX_BITS));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/tcd_frame_check.sv
module tcd_frame_check
    import tcd_pkg::*;
#(
    parameter int unsigned MAX_BITS = 60,
    parameter int unsigned CW       = $clog2(MAX_BITS + 1)
) (
    input  logic                       start_bit,
    input  logic [MAX_BITS-1:POS_CALL] kept,
    input  logic [CW-1:0]              count,
    output stamp_t                     fields,
    output logic                       ok
);
    logic len_ok, mark_ok, par_ok, zone_ok, min_ok, hour_ok, date_ok;
    logic [3:0] mon_u;
    logic       mon_t;

    assign fields.min      = kept[27:21];
    assign fields.hour     = kept[34:29];
    assign fields.mday     = kept[41:36];
    assign fields.wday     = kept[44:42];
    assign fields.mon      = kept[49:45];
    assign fields.year     = kept[57:50];
    assign fields.call     = kept[POS_CALL];
    assign fields.zone_ann = kept[POS_ZANN];
    assign fields.summer   = kept[POS_SUMMER];
    assign fields.winter   = kept[POS_WINTER];
    assign fields.leap_ann = kept[POS_LEAP];

    if (MAX_BITS > BASE_BITS) begin : g_leap
        assign len_ok = (count == CW'(BASE_BITS)) ||
                        (count == CW'(BASE_BITS + 1) && kept[POS_LEAP] && !kept[POS_EXTRA]);
    end else begin : g_plain
        assign len_ok = (count == CW'(BASE_BITS));
    end

    assign mark_ok = !start_bit && kept[POS_TIME];
    assign par_ok  = !(^kept[28:21]) && !(^kept[35:29]) && !(^kept[58:36]);
    assign zone_ok = kept[POS_SUMMER] ^ kept[POS_WINTER];

    assign min_ok  = (kept[24:21] <= 4'd9) && (kept[27:25] <= 3'd5);
    assign hour_ok = (kept[32:29] <= 4'd9) &&
                     ((kept[34:33] < 2'd2) || (kept[34:33] == 2'd2 && kept[32:29] <= 4'd3));

    assign mon_u = kept[48:45];
    assign mon_t = kept[49];

    always_comb begin
        date_ok = (kept[39:36] <= 4'd9) && (kept[44:42] != 3'd0) &&
                  (mon_u <= 4'd9) && !(mon_t == 1'b0 && mon_u == 4'd0) &&
                  (!mon_t || mon_u <= 4'd2) &&
                  (kept[53:50] <= 4'd9) && (kept[57:54] <= 4'd9);
    end

    assign ok = len_ok && mark_ok && par_ok && zone_ok && min_ok && hour_ok && date_ok;
endmodule

// File: rtl/tcd_decoder.sv
module tcd_decoder
    import tcd_pkg::*;
#(
    parameter int unsigned LEAP_ENABLE = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_val,
    input  logic       minute_mark,
    input  logic       frame_abort,
    output logic [6:0] min_bcd,
    output logic [5:0] hour_bcd,
    output logic [5:0] mday_bcd,
    output logic [2:0] wday,
    output logic [4:0] month_bcd,
    output logic [7:0] year_bcd,
    output logic       call_flag,
    output logic       zone_ann,
    output logic       summer_zone,
    output logic       winter_zone,
    output logic       leap_ann,
    output logic       frame_ok
);
    localparam int unsigned MAX_BITS = BASE_BITS + ((LEAP_ENABLE != 0) ? 1 : 0);
    localparam int unsigned CW       = $clog2(MAX_BITS + 1);

    dec_state_t st, st_nxt;
    logic                       clr, wr_en, full, chk_ok, accept;
    logic                       start_bit;
    logic [MAX_BITS-1:POS_CALL] kept;
    logic [CW-1:0]              count;
    stamp_t                     fields, stamp_q;

    tcd_bit_store #(.MAX_BITS(MAX_BITS), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_val(bit_val),
        .start_bit(start_bit), .kept(kept), .count(count), .full(full)
    );

    tcd_frame_check #(.MAX_BITS(MAX_BITS), .CW(CW)) u_check (
        .start_bit(start_bit), .kept(kept), .count(count),
        .fields(fields), .ok(chk_ok)
    );

    // Transitions: MARK_SEEN, MINUTE_END, ABORT, OVERRUN
    always_comb begin
        st_nxt = st;
        clr    = 1'b0;
        wr_en  = 1'b0;
        accept = 1'b0;
        unique case (st)
            ST_HUNT: begin
                clr = 1'b1;
                if (minute_mark && !frame_abort) st_nxt = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (frame_abort) begin
                    clr    = 1'b1;
                    st_nxt = ST_HUNT;
                end else if (minute_mark) begin
                    clr    = 1'b1;
                    accept = chk_ok;
                end else if (bit_vld && full) begin
                    clr    = 1'b1;
                    st_nxt = ST_HUNT;
                end else begin
                    wr_en = bit_vld;
                end
            end
            default: st_nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HUNT;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_ok <= 1'b0;
            stamp_q  <= '0;
        end else begin
            frame_ok <= accept;
            if (accept) stamp_q <= fields;
        end
    end

    assign min_bcd     = stamp_q.min;
    assign hour_bcd    = stamp_q.hour;
    assign mday_bcd    = stamp_q.mday;
    assign wday        = stamp_q.wday;
    assign month_bcd   = stamp_q.mon;
    assign year_bcd    = stamp_q.year;
    assign call_flag   = stamp_q.call;
    assign zone_ann    = stamp_q.zone_ann;
    assign summer_zone = stamp_q.summer;
    assign winter_zone = stamp_q.winter;
    assign leap_ann    = stamp_q.leap_ann;

    assert_ok_after_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> $past(minute_mark));
    assert_zone_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> (summer_zone != winter_zone));
    assert_digit_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> (min_bcd[3:0] <= 4'd9 && hour_bcd[3:0] <= 4'd9 &&
                      month_bcd[3:0] <= 4'd9 && year_bcd[3:0] <= 4'd9 && wday != 3'd0));
    assert_abort_hunt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |=> (st == ST_HUNT && !frame_ok));
    assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |-> $stable(stamp_q));
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> !frame_ok);
endmodule

// File: tb/tcd_decoder_test.sv
module tcd_decoder_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_vld = 1'b0, bit_val = 1'b0, minute_mark = 1'b0, frame_abort = 1'b0;
    logic [6:0] min_bcd;
    logic [5:0] hour_bcd, mday_bcd;
    logic [2:0] wday;
    logic [4:0] month_bcd;
    logic [7:0] year_bcd;
    logic call_flag, zone_ann, summer_zone, winter_zone, leap_ann, frame_ok;
    logic [39:0] dut_vec, last_good;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    tcd_decoder #(.LEAP_ENABLE(1)) uut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
        .minute_mark(minute_mark), .frame_abort(frame_abort),
        .min_bcd(min_bcd), .hour_bcd(hour_bcd), .mday_bcd(mday_bcd), .wday(wday),
        .month_bcd(month_bcd), .year_bcd(year_bcd), .call_flag(call_flag),
        .zone_ann(zone_ann), .summer_zone(summer_zone), .winter_zone(winter_zone),
        .leap_ann(leap_ann), .frame_ok(frame_ok)
    );

    assign dut_vec = {min_bcd, hour_bcd, mday_bcd, wday, month_bcd, year_bcd,
                      call_flag, zone_ann, summer_zone, winter_zone, leap_ann};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // flags = {call, zone_ann, summer, winter, leap}
    function automatic logic [59:0] mk(input logic [6:0] mi, input logic [5:0] hr,
            input logic [5:0] md, input logic [2:0] wd, input logic [4:0] mo,
            input logic [7:0] yr, input logic [4:0] fl);
        logic [59:0] f = '0;
        f[19:15] = {fl[0], fl[1], fl[2], fl[3], fl[4]};
        f[20] = 1'b1;
        f[27:21] = mi;  f[28] = ^mi;
        f[34:29] = hr;  f[35] = ^hr;
        f[41:36] = md;  f[44:42] = wd;  f[49:45] = mo;  f[57:50] = yr;
        f[58] = ^f[57:36];
        return f;
    endfunction

    function automatic logic [39:0] xv(input logic [59:0] f);
        return {f[27:21], f[34:29], f[41:36], f[44:42], f[49:45], f[57:50],
                f[15], f[16], f[17], f[18], f[19]};
    endfunction

    task automatic send_bit(input logic v);
        @(negedge clk); bit_vld = 1'b1; bit_val = v;
        @(negedge clk); bit_vld = 1'b0; bit_val = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bits(input logic [59:0] f, input int lo, input int hi);
        for (int i = lo; i < hi; i++) send_bit(i < 60 ? f[i] : 1'b0);
    endtask

    // Returns at the negedge after the edge that samples the strobe.
    task automatic mark();
        @(negedge clk); minute_mark = 1'b1;
        @(negedge clk); minute_mark = 1'b0;
    endtask

    task automatic expect_accept(input string req, input logic [59:0] f, input int n);
        send_bits(f, 0, n);
        mark();
        chk({req, " frame_ok"}, {63'd0, frame_ok}, 64'd1);
        chk({req, " fields"}, {24'd0, dut_vec}, {24'd0, xv(f)});
        @(negedge clk);
        chk("R11 single pulse", {63'd0, frame_ok}, 64'd0);
        last_good = xv(f);
    endtask

    task automatic expect_reject(input string req, input logic [59:0] f, input int n);
        send_bits(f, 0, n);
        mark();
        chk({req, " no frame_ok"}, {63'd0, frame_ok}, 64'd0);
        chk({req, " R10 outputs held"}, {24'd0, dut_vec}, {24'd0, last_good});
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", {24'd0, dut_vec}, 64'd0);
        chk("R1 reset frame_ok", {63'd0, frame_ok}, 64'd0);
        last_good = '0;
        expect_reject("R1 bits before first mark",
                      mk(7'h12, 6'h08, 6'h15, 3'd3, 5'h06, 8'h24, 5'b00101), 59);
    endtask

    task automatic t_good();
        expect_accept("R2 R12 frame A", mk(7'h47, 6'h13, 6'h28, 3'd2, 5'h02, 8'h25, 5'b11100), 59);
        expect_accept("R2 R6 limits", mk(7'h59, 6'h23, 6'h31, 3'd7, 5'h12, 8'h99, 5'b00010), 59);
        expect_accept("R2 R12 low edge", mk(7'h00, 6'h00, 6'h01, 3'd1, 5'h01, 8'h00, 5'b10010), 59);
    endtask

    task automatic t_marker();
        logic [59:0] f = mk(7'h30, 6'h10, 6'h10, 3'd4, 5'h07, 8'h30, 5'b00100);
        f[0] = 1'b1;
        expect_reject("R3 start bit set", f, 59);
        f = mk(7'h30, 6'h10, 6'h10, 3'd4, 5'h07, 8'h30, 5'b00100);
        f[20] = 1'b0;
        expect_reject("R3 time bit clear", f, 59);
    endtask

    task automatic t_parity();
        logic [59:0] g = mk(7'h21, 6'h05, 6'h09, 3'd5, 5'h11, 8'h41, 5'b00010);
        logic [59:0] f;
        f = g; f[28] = ~f[28]; expect_reject("R4 minute parity", f, 59);
        f = g; f[35] = ~f[35]; expect_reject("R4 hour parity", f, 59);
        f = g; f[58] = ~f[58]; expect_reject("R4 date parity", f, 59);
        f = g; f[40] = ~f[40]; expect_reject("R4 date data flip", f, 59);
    endtask

    task automatic t_zone();
        expect_reject("R5 both zones", mk(7'h15, 6'h12, 6'h05, 3'd1, 5'h03, 8'h20, 5'b00110), 59);
        expect_reject("R5 no zone", mk(7'h15, 6'h12, 6'h05, 3'd1, 5'h03, 8'h20, 5'b00000), 59);
    endtask

    task automatic t_range();
        expect_reject("R6 minute digit", mk(7'h1A, 6'h12, 6'h05, 3'd1, 5'h03, 8'h20, 5'b00100), 59);
        expect_reject("R6 minute 60", mk(7'h60, 6'h12, 6'h05, 3'd1, 5'h03, 8'h20, 5'b00100), 59);
        expect_reject("R6 hour 24", mk(7'h15, 6'h24, 6'h05, 3'd1, 5'h03, 8'h20, 5'b00100), 59);
        expect_reject("R6 month 0", mk(7'h15, 6'h12, 6'h05, 3'd1, 5'h00, 8'h20, 5'b00100), 59);
        expect_reject("R6 month 13", mk(7'h15, 6'h12, 6'h05, 3'd1, 5'h13, 8'h20, 5'b00100), 59);
        expect_reject("R6 weekday 0", mk(7'h15, 6'h12, 6'h05, 3'd0, 5'h03, 8'h20, 5'b00100), 59);
        expect_reject("R6 year digit", mk(7'h15, 6'h12, 6'h05, 3'd1, 5'h03, 8'hA0, 5'b00100), 59);
        expect_reject("R6 day digit", mk(7'h15, 6'h12, 6'h0C, 3'd1, 5'h03, 8'h20, 5'b00100), 59);
    endtask

    task automatic t_count();
        logic [59:0] g = mk(7'h44, 6'h17, 6'h22, 3'd6, 5'h09, 8'h33, 5'b00010);
        expect_reject("R7 58 bits", g, 58);
        expect_reject("R7 61 bits overrun", g, 61);
        expect_accept("R7 59 bits after overrun", g, 59);
    endtask

    task automatic t_leap();
        logic [59:0] g = mk(7'h00, 6'h01, 6'h01, 3'd4, 5'h01, 8'h26, 5'b00011);
        logic [59:0] f;
        expect_accept("R8 leap 60 bits", g, 60);
        f = mk(7'h00, 6'h01, 6'h01, 3'd4, 5'h01, 8'h26, 5'b00010);
        expect_reject("R8 60 bits unannounced", f, 60);
        f = g; f[59] = 1'b1;
        expect_reject("R8 extra bit one", f, 60);
        expect_accept("R8 leap frame 59 bits", g, 59);
    endtask

    task automatic t_abort();
        logic [59:0] g = mk(7'h38, 6'h20, 6'h14, 3'd3, 5'h10, 8'h27, 5'b01100);
        send_bits(g, 0, 30);
        @(negedge clk); frame_abort = 1'b1;
        @(negedge clk); frame_abort = 1'b0;
        send_bits(g, 30, 59);
        mark();
        chk("R9 abort no frame_ok", {63'd0, frame_ok}, 64'd0);
        chk("R9 abort outputs held", {24'd0, dut_vec}, {24'd0, last_good});
        expect_accept("R9 recovery", g, 59);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_marker();
        t_parity();
        t_zone();
        t_range();
        t_count();
        t_leap();
        t_abort();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule